// File: doc/BRIEF.md
# USB Pipe Configuration Guard

This block holds the per-pipe settings of a USB host/function controller that has one default control pipe (pipe 0) and nine numbered pipes (1 to 9). Each pipe stores a transfer kind, an endpoint number, a direction bit, a maximum packet size, a sequence-toggle bit and a 2-bit response handshake field. Software changes these settings through a single-cycle synchronous write port. The settings of any one pipe can be read back at any time through a combinational read port.

Every write goes through an interlock before it reaches the registers. A change to a protected setting is applied only while the pipe is stopped (handshake NAK) and its transfer engine reports it idle. Shape settings are also refused while any FIFO port is pointed at the pipe. Transfer kinds and endpoint numbers are checked against what each pipe number allows. Two numbered pipes may not share a direction/endpoint pair. A refused write changes nothing and raises a sticky error flag. A change to the default control pipe raises a flag that stays up until its buffer is cleared.

Top module: `usb_pipe_cfg_guard`

## Requirements
- R1: After reset every pipe reads handshake 00 (NAK), kind 00, direction 0, endpoint 0, max packet 0 and toggle 0, and the flags wr_err, dup_conflict and dcp_stale are all 0.
- R2: A handshake write (wr_field 00, value wr_data[1:0]) to any pipe 0 to 9 is applied whatever the pipe's busy, handshake or FIFO-port state.
- R3: Writes to the shape field (wr_field 01), the packet-size field (wr_field 10) or the toggle field (wr_field 11) are refused while the target pipe's handshake is not 00 or its busy input is 1.
- R4: Shape and packet-size writes are also refused while any of the three 4-bit selectors in port_sel (bits [3:0], [7:4], [11:8]) equals the target pipe number. Toggle writes are not subject to this check.
- R5: Shape data is wr_data[1:0] kind (00 none, 01 bulk, 10 interrupt, 11 isochronous), wr_data[2] direction and wr_data[6:3] endpoint. Pipes 1 and 2 accept only bulk or isochronous, pipes 3 to 5 only bulk, and pipes 6 to 9 only interrupt. Any other kind is refused.
- R6: A shape write to pipes 1 to 9 with endpoint 0 is refused.
- R7: A shape write to pipes 1 to 9 is refused if another configured pipe (kind not 00) already holds the same direction and endpoint. Such a refusal sets the sticky dup_conflict flag. Rewriting a pipe's own pair is allowed.
- R8: On pipe 0 a shape write updates only the direction bit. Kind and endpoint always read 00 and 0.
- R9: A refused write leaves every field of every pipe unchanged and sets wr_err on the next edge. err_clr clears wr_err and dup_conflict, and a new refusal in the same cycle as err_clr wins.
- R10: An accepted shape or packet-size write to pipe 0 sets dcp_stale. A buf_clr pulse clears it, and a new set wins over a simultaneous clear.
- R11: Packet-size data is wr_data[10:0]. For toggle writes, wr_data[0]=1 clears the toggle and otherwise wr_data[1]=1 sets it.
- R12: Any write addressed to a pipe number above 9 is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_pipe | input | 4 | Target pipe number |
| wr_field | input | 2 | 00 handshake, 01 shape, 10 packet size, 11 toggle |
| wr_data | input | 11 | Write data |
| err_clr | input | 1 | Clears wr_err and dup_conflict |
| buf_clr | input | 1 | Pipe-0 buffer clear, clears dcp_stale |
| busy | input | 10 | Per-pipe busy from transfer engine |
| port_sel | input | 12 | Three 4-bit FIFO port pipe selectors |
| rd_pipe | input | 4 | Pipe to read back |
| rd_pid | output | 2 | Handshake of rd_pipe |
| rd_kind | output | 2 | Transfer kind of rd_pipe |
| rd_dir | output | 1 | Direction of rd_pipe |
| rd_ep | output | 4 | Endpoint of rd_pipe |
| rd_mps | output | 11 | Max packet size of rd_pipe |
| rd_seq | output | 1 | Toggle bit of rd_pipe |
| wr_err | output | 1 | Sticky refused-write flag |
| dup_conflict | output | 1 | Sticky duplicate-pair flag |
| dcp_stale | output | 1 | Pipe-0 changed, buffer clear pending |

## Verification
The assertions assume that busy and port_sel are stable in the cycle a write is sampled, and that wr_field is always one of its four codes. Apart from that, the interlock checks hold for any input sequence. The bench changes busy, port_sel, err_clr and buf_clr only on falling edges, and keeps idle port selectors at 15, a value that matches no pipe. That way each refusal has a single known cause, and the flags are seen one edge after the write that caused them.

// File: rtl/usb_pipe_cfg_pkg.sv
package usb_pipe_cfg_pkg;
    localparam int NPIPE = 10;
    localparam int PIPEW = 4;
    localparam int EPW   = 4;
    localparam int MPSW  = 11;
    localparam int DW    = MPSW;
    localparam int NPORT = 3;

    typedef enum logic [1:0] {
        XF_NONE = 2'b00,
        XF_BULK = 2'b01,
        XF_INTR = 2'b10,
        XF_ISO  = 2'b11
    } xfer_t;

    typedef enum logic [1:0] {
        F_PID = 2'b00,
        F_CFG = 2'b01,
        F_MPS = 2'b10,
        F_SEQ = 2'b11
    } field_t;

    localparam logic [1:0] PID_NAK = 2'b00;

    typedef struct packed {
        xfer_t            kind;
        logic             dir;
        logic [EPW-1:0]   ep;
        logic [MPSW-1:0]  mps;
        logic [1:0]       pid;
        logic             seq;
    } pipe_st_t;

    // Which transfer kinds a numbered pipe may take
    function automatic logic kind_legal(input logic [PIPEW-1:0] p, input xfer_t k);
        if (p == 1 || p == 2)      return (k == XF_BULK) || (k == XF_ISO);
        else if (p >= 3 && p <= 5) return (k == XF_BULK);
        else if (p >= 6 && p <= 9) return (k == XF_INTR);
        else                       return 1'b0;
    endfunction
endpackage

// File: rtl/pipe_slot.sv
module pipe_slot
    import usb_pipe_cfg_pkg::*;
#(
    parameter int IDX = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_pid,
    input  logic          we_cfg,
    input  logic          we_mps,
    input  logic          we_seq,
    input  logic [DW-1:0] wdata,
    output pipe_st_t      st
);
    localparam bool_fixed = (IDX == 0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (we_pid) st.pid <= wdata[1:0];
            if (we_cfg) begin
                st.dir <= wdata[2];
                if (!bool_fixed) begin
                    st.kind <= xfer_t'(wdata[1:0]);
                    st.ep   <= wdata[6:3];
                end
            end
            if (we_mps) st.mps <= wdata[MPSW-1:0];
            if (we_seq) begin
                if (wdata[0])      st.seq <= 1'b0;
                else if (wdata[1]) st.seq <= 1'b1;
            end
        end
    end

    generate
        if (IDX != 0) begin : g_num
            // R6
            ep_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
                (st.kind != XF_NONE) |-> (st.ep != '0));
            // R5
            kind_allowed_chk: assert property (@(posedge clk) disable iff (rst)
                (st.kind != XF_NONE) |-> kind_legal(PIPEW'(IDX), st.kind));
        end
    endgenerate
endmodule

// File: rtl/pipe_dup_check.sv
module pipe_dup_check
    import usb_pipe_cfg_pkg::*;
(
    input  xfer_t            kind [NPIPE],
    input  logic             dir  [NPIPE],
    input  logic [EPW-1:0]   ep   [NPIPE],
    input  logic [PIPEW-1:0] tgt,
    input  logic             new_dir,
    input  logic [EPW-1:0]   new_ep,
    output logic             dup
);
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < NPIPE; i++) begin
            if (PIPEW'(i) != tgt && kind[i] != XF_NONE &&
                dir[i] == new_dir && ep[i] == new_ep)
                dup = 1'b1;
        end
    end
endmodule

// File: rtl/pipe_write_guard.sv
module pipe_write_guard
    import usb_pipe_cfg_pkg::*;
(
    input  logic                   wr_en,
    input  field_t                 field,
    input  logic [PIPEW-1:0]       pipe,
    input  xfer_t                  new_kind,
    input  logic [EPW-1:0]         new_ep,
    input  logic [1:0]             pid [NPIPE],
    input  logic [NPIPE-1:0]       busy,
    input  logic [NPORT*PIPEW-1:0] port_sel,
    input  logic                   dup,
    output logic                   accept,
    output logic                   reject,
    output logic                   conflict
);
    logic in_range, idle, port_hit, fixed, shape_ok, ok;

    always_comb begin
        in_range = (pipe < PIPEW'(NPIPE));
        idle = 1'b0;
        for (int i = 0; i < NPIPE; i++)
            if (pipe == PIPEW'(i)) idle = (pid[i] == PID_NAK) && !busy[i];
        port_hit = 1'b0;
        for (int k = 0; k < NPORT; k++)
            if (port_sel[k*PIPEW +: PIPEW] == pipe) port_hit = 1'b1;
        fixed    = (pipe == '0);
        shape_ok = fixed || (kind_legal(pipe, new_kind) && new_ep != '0);
        unique case (field)
            F_PID:   ok = in_range;
            F_SEQ:   ok = in_range && idle;
            F_MPS:   ok = in_range && idle && !port_hit;
            F_CFG:   ok = in_range && idle && !port_hit && shape_ok && (fixed || !dup);
            default: ok = 1'b0;
        endcase
        accept   = wr_en && ok;
        reject   = wr_en && !ok;
        conflict = wr_en && field == F_CFG && in_range && idle && !port_hit &&
                   shape_ok && !fixed && dup;
    end
endmodule

// File: rtl/usb_pipe_cfg_guard.sv
module usb_pipe_cfg_guard
    import usb_pipe_cfg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [PIPEW-1:0]       wr_pipe,
    input  logic [1:0]             wr_field,
    input  logic [DW-1:0]          wr_data,
    input  logic                   err_clr,
    input  logic                   buf_clr,
    input  logic [NPIPE-1:0]       busy,
    input  logic [NPORT*PIPEW-1:0] port_sel,
    input  logic [PIPEW-1:0]       rd_pipe,
    output logic [1:0]             rd_pid,
    output logic [1:0]             rd_kind,
    output logic                   rd_dir,
    output logic [EPW-1:0]         rd_ep,
    output logic [MPSW-1:0]        rd_mps,
    output logic                   rd_seq,
    output logic                   wr_err,
    output logic                   dup_conflict,
    output logic                   dcp_stale
);
    field_t   fld;
    pipe_st_t st   [NPIPE];
    xfer_t    kind_a [NPIPE];
    logic     dir_a  [NPIPE];
    logic [EPW-1:0] ep_a  [NPIPE];
    logic [1:0]     pid_a [NPIPE];
    logic dup, acc, rej, conf, stale_set;

    assign fld = field_t'(wr_field);

    genvar g;
    generate
        for (g = 0; g < NPIPE; g++) begin : g_pipe
            logic hit;
            assign hit = acc && (wr_pipe == PIPEW'(g));
            pipe_slot #(.IDX(g)) u_slot (
                .clk    (clk),
                .rst    (rst),
                .we_pid (hit && fld == F_PID),
                .we_cfg (hit && fld == F_CFG),
                .we_mps (hit && fld == F_MPS),
                .we_seq (hit && fld == F_SEQ),
                .wdata  (wr_data),
                .st     (st[g])
            );
            assign kind_a[g] = st[g].kind;
            assign dir_a[g]  = st[g].dir;
            assign ep_a[g]   = st[g].ep;
            assign pid_a[g]  = st[g].pid;
        end
    endgenerate

    pipe_dup_check u_dup (
        .kind    (kind_a),
        .dir     (dir_a),
        .ep      (ep_a),
        .tgt     (wr_pipe),
        .new_dir (wr_data[2]),
        .new_ep  (wr_data[6:3]),
        .dup     (dup)
    );

    pipe_write_guard u_guard (
        .wr_en    (wr_en),
        .field    (fld),
        .pipe     (wr_pipe),
        .new_kind (xfer_t'(wr_data[1:0])),
        .new_ep   (wr_data[6:3]),
        .pid      (pid_a),
        .busy     (busy),
        .port_sel (port_sel),
        .dup      (dup),
        .accept   (acc),
        .reject   (rej),
        .conflict (conf)
    );

    assign stale_set = acc && wr_pipe == '0 && (fld == F_CFG || fld == F_MPS);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_err       <= 1'b0;
            dup_conflict <= 1'b0;
            dcp_stale    <= 1'b0;
        end else begin
            if (rej)          wr_err <= 1'b1;
            else if (err_clr) wr_err <= 1'b0;
            if (conf)         dup_conflict <= 1'b1;
            else if (err_clr) dup_conflict <= 1'b0;
            if (stale_set)    dcp_stale <= 1'b1;
            else if (buf_clr) dcp_stale <= 1'b0;
        end
    end

    always_comb begin
        rd_pid = '0; rd_kind = '0; rd_dir = 1'b0; rd_ep = '0; rd_mps = '0; rd_seq = 1'b0;
        for (int i = 0; i < NPIPE; i++) begin
            if (rd_pipe == PIPEW'(i)) begin
                rd_pid  = st[i].pid;
                rd_kind = st[i].kind;
                rd_dir  = st[i].dir;
                rd_ep   = st[i].ep;
                rd_mps  = st[i].mps;
                rd_seq  = st[i].seq;
            end
        end
    end

    // Monitors for the interlock assertions
    logic mon_idle, mon_port;
    always_comb begin
        mon_idle = 1'b0;
        for (int i = 0; i < NPIPE; i++)
            if (wr_pipe == PIPEW'(i)) mon_idle = (st[i].pid == PID_NAK) && !busy[i];
        mon_port = (port_sel[3:0] == wr_pipe) || (port_sel[7:4] == wr_pipe) ||
                   (port_sel[11:8] == wr_pipe);
    end

    // R3
    prot_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && fld != F_PID) |-> mon_idle);
    // R4
    port_block_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && (fld == F_CFG || fld == F_MPS)) |-> !mon_port);
    // R12
    range_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_pipe >= PIPEW'(NPIPE)) |-> !acc);
    // R9
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        rej |=> wr_err);
    // R7
    conflict_set_chk: assert property (@(posedge clk) disable iff (rst)
        conf |=> dup_conflict);
    // R10
    stale_set_chk: assert property (@(posedge clk) disable iff (rst)
        stale_set |=> dcp_stale);

    generate
        for (genvar a = 1; a < NPIPE; a++) begin : g_pa
            for (genvar b = a + 1; b < NPIPE; b++) begin : g_pb
                // R7
                pair_unique_chk: assert property (@(posedge clk) disable iff (rst)
                    !(st[a].kind != XF_NONE && st[b].kind != XF_NONE &&
                      st[a].dir == st[b].dir && st[a].ep == st[b].ep));
            end
        end
    endgenerate
endmodule

// File: tb/usb_pipe_cfg_guard_test.sv
module usb_pipe_cfg_guard_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_pipe;
    logic [1:0]  wr_field;
    logic [10:0] wr_data;
    logic        err_clr, buf_clr;
    logic [9:0]  busy;
    logic [11:0] port_sel;
    logic [3:0]  rd_pipe;
    logic [1:0]  rd_pid, rd_kind;
    logic        rd_dir, rd_seq;
    logic [3:0]  rd_ep;
    logic [10:0] rd_mps;
    logic        wr_err, dup_conflict, dcp_stale;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    usb_pipe_cfg_guard uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_pipe(wr_pipe), .wr_field(wr_field),
        .wr_data(wr_data), .err_clr(err_clr), .buf_clr(buf_clr), .busy(busy),
        .port_sel(port_sel), .rd_pipe(rd_pipe), .rd_pid(rd_pid), .rd_kind(rd_kind),
        .rd_dir(rd_dir), .rd_ep(rd_ep), .rd_mps(rd_mps), .rd_seq(rd_seq),
        .wr_err(wr_err), .dup_conflict(dup_conflict), .dcp_stale(dcp_stale)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] shape(input int kind, input int dir, input int ep);
        return 11'((ep << 3) | (dir << 2) | kind);
    endfunction

    task automatic wr(input int p, input int f, input logic [10:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_pipe = 4'(p); wr_field = 2'(f); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clr_err();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic look(input int p);
        rd_pipe = 4'(p);
        #1;
    endtask

    task automatic t_reset();
        for (int p = 0; p < 10; p++) begin
            look(p);
            chk("R1 pid", rd_pid, 0);
            chk("R1 kind", rd_kind, 0);
            chk("R1 cfg", {rd_dir, rd_ep, rd_mps, rd_seq}, 0);
        end
        chk("R1 flags", {wr_err, dup_conflict, dcp_stale}, 0);
    endtask

    task automatic t_handshake();
        busy[3] = 1'b1;
        wr(3, 0, 11'd1);
        look(3); chk("R2 pid write while busy", rd_pid, 1);
        chk("R2 no error", wr_err, 0);
        busy[3] = 1'b0;
        wr(3, 1, shape(1, 0, 2));
        look(3); chk("R3 refused when BUF kind", rd_kind, 0);
        chk("R9 error set", wr_err, 1);
        clr_err(); chk("R9 err_clr", wr_err, 0);
        wr(3, 0, 11'd0);
        busy[3] = 1'b1;
        wr(3, 2, 11'd64);
        look(3); chk("R3 refused when busy mps", rd_mps, 0);
        chk("R3 busy error", wr_err, 1);
        clr_err();
        busy[3] = 1'b0;
        wr(3, 1, shape(1, 0, 2));
        look(3); chk("R5 bulk on pipe3 kind", rd_kind, 1);
        chk("R5 bulk on pipe3 ep", rd_ep, 2);
    endtask

    task automatic t_port();
        port_sel = 12'hF4F;  // middle selector points at pipe 4
        wr(4, 1, shape(1, 1, 9));
        look(4); chk("R4 shape refused under port", rd_kind, 0);
        chk("R4 error", wr_err, 1);
        clr_err();
        wr(4, 2, 11'd200);
        look(4); chk("R4 mps refused under port", rd_mps, 0);
        clr_err();
        wr(4, 3, 11'd2);
        look(4); chk("R4 R11 toggle set under port", rd_seq, 1);
        chk("R4 toggle no error", wr_err, 0);
        port_sel = 12'hFFF;
        wr(4, 2, 11'd1023);
        look(4); chk("R11 mps value", rd_mps, 1023);
        wr(4, 3, 11'd3);
        look(4); chk("R11 clear wins", rd_seq, 0);
    endtask

    task automatic t_kinds();
        wr(1, 1, shape(2, 0, 1));
        look(1); chk("R5 interrupt refused pipe1", rd_kind, 0);
        clr_err();
        wr(1, 1, shape(3, 1, 1));
        look(1); chk("R5 iso pipe1", {rd_kind, rd_dir, rd_ep}, {2'd3, 1'b1, 4'd1});
        wr(6, 1, shape(1, 0, 3));
        look(6); chk("R5 bulk refused pipe6", rd_kind, 0);
        clr_err();
        wr(6, 1, shape(2, 0, 3));
        look(6); chk("R5 interrupt pipe6", {rd_kind, rd_ep}, {2'd2, 4'd3});
        wr(7, 1, shape(2, 0, 0));
        look(7); chk("R6 ep0 refused", rd_kind, 0);
        chk("R6 error", wr_err, 1);
        clr_err();
    endtask

    task automatic t_dup();
        wr(8, 1, shape(2, 0, 3));
        look(8); chk("R7 dup refused", rd_kind, 0);
        chk("R7 conflict flag", dup_conflict, 1);
        look(6); chk("R9 other pipe untouched", {rd_kind, rd_ep}, {2'd2, 4'd3});
        clr_err(); chk("R9 conflict cleared", dup_conflict, 0);
        wr(8, 1, shape(2, 1, 3));
        look(8); chk("R7 other dir ok", {rd_kind, rd_dir}, {2'd2, 1'b1});
        wr(6, 1, shape(2, 0, 3));
        chk("R7 self rewrite ok", wr_err, 0);
    endtask

    task automatic t_dcp();
        wr(0, 1, shape(1, 1, 5));
        look(0); chk("R8 pipe0 fixed", {rd_kind, rd_ep}, 0);
        chk("R8 pipe0 dir", rd_dir, 1);
        chk("R10 stale set", dcp_stale, 1);
        @(negedge clk); buf_clr = 1'b1;
        @(negedge clk); buf_clr = 1'b0;
        chk("R10 stale cleared", dcp_stale, 0);
        wr(0, 2, 11'd64);
        look(0); chk("R10 mps pipe0", rd_mps, 64);
        chk("R10 stale again", dcp_stale, 1);
    endtask

    task automatic t_range();
        wr(12, 0, 11'd1);
        chk("R12 pipe 12 refused", wr_err, 1);
        @(negedge clk);
        err_clr = 1'b1; wr_en = 1'b1; wr_pipe = 4'd15; wr_field = 2'd0; wr_data = 11'd1;
        @(negedge clk);
        err_clr = 1'b0; wr_en = 1'b0;
        chk("R9 set wins over clear", wr_err, 1);
        clr_err();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_pipe = '0; wr_field = '0; wr_data = '0;
        err_clr = 1'b0; buf_clr = 1'b0; busy = '0; port_sel = 12'hFFF; rd_pipe = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_port();
        t_kinds();
        t_dup();
        t_dcp();
        t_range();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule